// File: doc/BRIEF.md
# UART Interrupt Mask and Status Unit

This block gathers the eleven interrupt sources of a UART core and turns them into grouped interrupt lines. Four active-low modem lines (ring indicator, clear-to-send, carrier detect, data-set-ready) pass through a two-flop synchronizer. An edge detector then flags any change on them, rising or falling. Four receive-error events (framing, parity, break, overrun) arrive as single-cycle pulses. Three dataflow conditions (receive, transmit, receive timeout) arrive as levels from the FIFO logic.

The modem and error events are held in sticky raw bits. The dataflow raw bits follow their input levels. A programmable enable mask gates the raw bits. The masked bits drive five grouped outputs and one combined line.

Software uses a small register port with four addresses: the mask (read/write), the raw status (read only), the masked status (read only) and a write-one-to-clear register. A read returns its data one cycle after the request. Clearing a dataflow bit cannot reset a level, so that write sends a one-cycle clear pulse back to the FIFO logic instead.

The access sequencer has two named states. ST_IDLE waits for requests. ST_RESP presents read data for one cycle. The transitions are:
- ST_IDLE to ST_RESP on a read request.
- ST_RESP to ST_RESP on a read request in the response cycle.
- ST_RESP to ST_IDLE when no read is requested.
- ST_IDLE to ST_IDLE otherwise.

Top module: `uirq_top`

## Requirements
- R1: After reset the mask and every raw bit are zero, and all six interrupt outputs and all clear pulses are low.
- R2: A write to address 0 loads the mask from wdata[10:0]. A read of address 0 returns the mask, with bits 15 to 11 reading as zero.
- R3: A change in either direction on a modem line sets its raw bit: bit 0 ring, bit 1 clear-to-send, bit 2 carrier detect, bit 3 data-set-ready. The bit is set within four clock cycles of the change and stays set until it is cleared.
- R4: An error pulse sets its sticky raw bit: bit 7 framing, bit 8 parity, bit 9 break, bit 10 overrun.
- R5: A write to address 3 clears every sticky raw bit whose wdata bit is 1 and leaves bits written as 0 unchanged. If a new event and a clear of the same bit happen in the same cycle, the bit stays set.
- R6: Raw bits 4 (receive), 5 (transmit) and 6 (receive timeout) follow the levels on rx_lvl, tx_lvl and rt_lvl.
- R7: A write to address 3 with bit 4, 5 or 6 set drives rx_clr, tx_clr or rt_clr high for exactly the one cycle after the write.
- R8: A read of address 1 returns the raw status. A read of address 2 returns raw AND mask.
- R9: irq_rx, irq_tx and irq_rt are masked bits 4, 5 and 6. irq_ms is the OR of masked bits 0 to 3. irq_err is the OR of masked bits 7 to 10.
- R10: irq_any is the OR of the five grouped outputs, and stays low whenever the mask is zero.
- R11: rd_valid is high with rd_data in the cycle after a read request. A read of address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Register access strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | 0 mask, 1 raw, 2 masked, 3 clear |
| wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |
| ri_n | input | 1 | Ring indicator, active low |
| cts_n | input | 1 | Clear-to-send, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| fe_pulse | input | 1 | Framing error event |
| pe_pulse | input | 1 | Parity error event |
| be_pulse | input | 1 | Break event |
| oe_pulse | input | 1 | Overrun event |
| rx_lvl | input | 1 | Receive trigger level reached |
| tx_lvl | input | 1 | Transmit trigger level reached |
| rt_lvl | input | 1 | Receive timeout condition |
| rx_clr | output | 1 | Receive clear pulse to FIFO logic |
| tx_clr | output | 1 | Transmit clear pulse to FIFO logic |
| rt_clr | output | 1 | Timeout clear pulse to FIFO logic |
| irq_rx | output | 1 | Masked receive interrupt |
| irq_tx | output | 1 | Masked transmit interrupt |
| irq_rt | output | 1 | Masked receive-timeout interrupt |
| irq_ms | output | 1 | Modem-status summary interrupt |
| irq_err | output | 1 | Error summary interrupt |
| irq_any | output | 1 | OR of the five grouped interrupts |

## Verification
The hardest case to reach from the ports is a new error event and a clear of the same bit landing on one clock edge. The bench raises the framing pulse and the clear-register write on the same falling edge, so both land on the next rising edge. It then reads back the raw status to confirm that the bit survived. Modem-line changes pass through the synchronizer, so the stimulus waits several cycles before it samples. Both edge directions are covered by clearing the bit between a falling and a rising change.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    localparam int SRC_N   = 11;
    localparam int DATA_W  = 16;
    localparam int MODEM_N = 4;
    localparam int ERR_N   = 4;
    localparam int STICKY_N = MODEM_N + ERR_N;

    localparam int B_RX = 4;
    localparam int B_TX = 5;
    localparam int B_RT = 6;
    localparam int B_ERR_LO = 7;

    typedef enum logic [1:0] {
        REG_MASK   = 2'd0,
        REG_RAW    = 2'd1,
        REG_MASKED = 2'd2,
        REG_CLEAR  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } acc_state_e;
endpackage

// File: rtl/uirq_line_watch.sv
module uirq_line_watch #(
    parameter int   N         = 4,
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_i,
    output logic [N-1:0] chg_o
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic s1_q, s2_q, prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q   <= IDLE_LEVEL;
                s2_q   <= IDLE_LEVEL;
                prev_q <= IDLE_LEVEL;
            end else begin
                s1_q   <= line_i[i];
                s2_q   <= s1_q;
                prev_q <= s2_q;
            end
        end

        assign chg_o[i] = s2_q ^ prev_q;
    end
endmodule

// File: rtl/uirq_sticky.sv
module uirq_sticky #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] bits_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic bit_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else if (set_i[i])
                bit_q <= 1'b1;
            else if (clr_i[i])
                bit_q <= 1'b0;
        end

        assign bits_o[i] = bit_q;

        a_r4_set_holds: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> bits_o[i]);
        a_r5_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !bits_o[i]);
        a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (bits_o[i] && !clr_i[i]) |=> bits_o[i]);
    end
endmodule

// File: rtl/uirq_reg_if.sv
module uirq_reg_if
    import uirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [SRC_N-1:0]  raw_i,
    output logic [SRC_N-1:0]  mask_o,
    output logic [SRC_N-1:0]  w1c_o,
    output logic [2:0]        dflow_clr_o,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int PAD_W = DATA_W - SRC_N;

    acc_state_e        state_q, state_d;
    reg_sel_e          sel;
    logic              rd_req, wr_req;
    logic [SRC_N-1:0]  mask_q;
    logic [DATA_W-1:0] rd_next, rd_q;
    logic [2:0]        dclr_q;
    logic              unused_hi;

    assign sel       = reg_sel_e'(addr_i);
    assign rd_req    = req_i && !we_i;
    assign wr_req    = req_i && we_i;
    assign unused_hi = ^wdata_i[DATA_W-1:SRC_N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_req) state_d = ST_RESP;
            ST_RESP: state_d = rd_req ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_valid_o = (state_q == ST_RESP);
        rd_data_o  = rd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_req && sel == REG_MASK)
            mask_q <= wdata_i[SRC_N-1:0];
    end

    always_comb begin
        rd_next = '0;
        unique case (sel)
            REG_MASK:   rd_next = {{PAD_W{1'b0}}, mask_q};
            REG_RAW:    rd_next = {{PAD_W{1'b0}}, raw_i};
            REG_MASKED: rd_next = {{PAD_W{1'b0}}, raw_i & mask_q};
            REG_CLEAR:  rd_next = '0;
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_q <= '0;
        else if (rd_req)
            rd_q <= rd_next;
    end

    assign w1c_o = (wr_req && sel == REG_CLEAR) ? wdata_i[SRC_N-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dclr_q <= '0;
        else
            dclr_q <= w1c_o[B_RT:B_RX];
    end

    assign mask_o      = mask_q;
    assign dflow_clr_o = dclr_q;

    a_r2_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && sel == REG_MASK) |=> (mask_o == $past(wdata_i[SRC_N-1:0])));
    a_r11_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid_o);
    a_r2_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> (rd_data_o[DATA_W-1:SRC_N] == '0));
    a_r7_clr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req && sel == REG_CLEAR) |=> (dflow_clr_o == 3'b000));
endmodule

// File: rtl/uirq_top.sv
module uirq_top
    import uirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ri_n,
    input  logic              cts_n,
    input  logic              dcd_n,
    input  logic              dsr_n,
    input  logic              fe_pulse,
    input  logic              pe_pulse,
    input  logic              be_pulse,
    input  logic              oe_pulse,
    input  logic              rx_lvl,
    input  logic              tx_lvl,
    input  logic              rt_lvl,
    output logic              rx_clr,
    output logic              tx_clr,
    output logic              rt_clr,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_rt,
    output logic              irq_ms,
    output logic              irq_err,
    output logic              irq_any
);
    logic [MODEM_N-1:0]  modem_chg;
    logic [STICKY_N-1:0] st_set, st_clr, st_bits;
    logic [SRC_N-1:0]    raw, mask, w1c, masked;
    logic [2:0]          dclr;

    uirq_line_watch #(.N(MODEM_N), .IDLE_LEVEL(1'b1)) u_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i ({dsr_n, dcd_n, cts_n, ri_n}),
        .chg_o  (modem_chg)
    );

    assign st_set = {oe_pulse, be_pulse, pe_pulse, fe_pulse, modem_chg};
    assign st_clr = {w1c[SRC_N-1:B_ERR_LO], w1c[MODEM_N-1:0]};

    uirq_sticky #(.N(STICKY_N)) u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (st_set),
        .clr_i  (st_clr),
        .bits_o (st_bits)
    );

    assign raw = {st_bits[STICKY_N-1:MODEM_N], rt_lvl, tx_lvl, rx_lvl,
                  st_bits[MODEM_N-1:0]};

    uirq_reg_if u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .we_i        (we),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .raw_i       (raw),
        .mask_o      (mask),
        .w1c_o       (w1c),
        .dflow_clr_o (dclr),
        .rd_valid_o  (rd_valid),
        .rd_data_o   (rd_data)
    );

    assign masked  = raw & mask;
    assign irq_rx  = masked[B_RX];
    assign irq_tx  = masked[B_TX];
    assign irq_rt  = masked[B_RT];
    assign irq_ms  = |masked[MODEM_N-1:0];
    assign irq_err = |masked[SRC_N-1:B_ERR_LO];
    assign irq_any = irq_rx | irq_tx | irq_rt | irq_ms | irq_err;

    assign rx_clr = dclr[0];
    assign tx_clr = dclr[1];
    assign rt_clr = dclr[2];

    a_r10_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_any);
    a_r9_err_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_err) |-> ($past(st_set[STICKY_N-1:MODEM_N]) != '0 || $past(mask) != mask));
endmodule

// File: tb/uirq_top_bench.sv
module uirq_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        ri_n = 1'b1, cts_n = 1'b1, dcd_n = 1'b1, dsr_n = 1'b1;
    logic        fe_pulse = 1'b0, pe_pulse = 1'b0, be_pulse = 1'b0, oe_pulse = 1'b0;
    logic        rx_lvl = 1'b0, tx_lvl = 1'b0, rt_lvl = 1'b0;
    logic        rx_clr, tx_clr, rt_clr;
    logic        irq_rx, irq_tx, irq_rt, irq_ms, irq_err, irq_any;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    uirq_top u_uirq_top (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .ri_n(ri_n), .cts_n(cts_n), .dcd_n(dcd_n), .dsr_n(dsr_n),
        .fe_pulse(fe_pulse), .pe_pulse(pe_pulse), .be_pulse(be_pulse), .oe_pulse(oe_pulse),
        .rx_lvl(rx_lvl), .tx_lvl(tx_lvl), .rt_lvl(rt_lvl),
        .rx_clr(rx_clr), .tx_clr(tx_clr), .rt_clr(rt_clr),
        .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_rt(irq_rt),
        .irq_ms(irq_ms), .irq_err(irq_err), .irq_any(irq_any)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, int exp, string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares read responses against the scoreboard queue
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rd_valid) begin
                if (exp_q.size() == 0) begin
                    chk("R11 unexpected response", 1, 0);
                end else begin
                    chk(tag_q.pop_front(), int'(rd_data), exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        chk("R1 irq_any", irq_any, 0);
        chk("R1 irq group", {irq_rx, irq_tx, irq_rt, irq_ms, irq_err}, 0);
        chk("R1 clr pulses", {rx_clr, tx_clr, rt_clr}, 0);
        rd(2'd1, 'h000, "R1 raw after reset");
        rd(2'd0, 'h000, "R1 mask after reset");

        // R2 mask write, upper bits read zero; R11 clear reg reads zero
        wr(2'd0, 16'hFFFF);
        rd(2'd0, 'h7FF, "R2 mask readback");
        rd(2'd3, 'h000, "R11 clear reg reads zero");

        // R3 falling edge on ring indicator
        @(negedge clk); ri_n = 1'b0;
        idle(4);
        chk("R3 irq_ms after ri fall", irq_ms, 1);
        chk("R10 irq_any after ri fall", irq_any, 1);
        rd(2'd1, 'h001, "R3 raw ring bit");
        wr(2'd3, 16'h0001);
        rd(2'd1, 'h000, "R5 ring cleared");
        chk("R9 irq_ms after clear", irq_ms, 0);
        // R3 rising edge
        @(negedge clk); ri_n = 1'b1;
        idle(4);
        rd(2'd1, 'h001, "R3 ring rising edge");
        // R3 dsr and cts
        @(negedge clk); dsr_n = 1'b0; cts_n = 1'b0;
        idle(4);
        rd(2'd1, 'h00B, "R3 dsr and cts bits");
        wr(2'd3, 16'h0002);
        rd(2'd1, 'h009, "R5 partial clear keeps others");
        wr(2'd3, 16'h000F);
        rd(2'd1, 'h000, "R5 modem all cleared");

        // R4 error pulses
        @(negedge clk); fe_pulse = 1'b1; oe_pulse = 1'b1;
        @(negedge clk); fe_pulse = 1'b0; oe_pulse = 1'b0; pe_pulse = 1'b1; be_pulse = 1'b1;
        @(negedge clk); pe_pulse = 1'b0; be_pulse = 1'b0;
        idle(2);
        rd(2'd1, 'h780, "R4 error bits sticky");
        chk("R9 irq_err", irq_err, 1);
        wr(2'd3, 16'h0180);
        rd(2'd1, 'h600, "R5 clear fe pe only");
        wr(2'd3, 16'h0600);
        rd(2'd1, 'h000, "R5 errors cleared");
        chk("R9 irq_err after clear", irq_err, 0);

        // R5 set wins over clear
        @(negedge clk); fe_pulse = 1'b1;
        @(negedge clk); fe_pulse = 1'b0;
        @(negedge clk);
        fe_pulse = 1'b1; req = 1'b1; we = 1'b1; addr = 2'd3; wdata = 16'h0080;
        @(negedge clk);
        fe_pulse = 1'b0; req = 1'b0; we = 1'b0;
        rd(2'd1, 'h080, "R5 new event wins over clear");
        wr(2'd3, 16'h0080);
        rd(2'd1, 'h000, "R5 fe cleared alone");

        // R6 levels, R7 clear pulses
        @(negedge clk); rx_lvl = 1'b1; tx_lvl = 1'b1; rt_lvl = 1'b1;
        @(negedge clk);
        chk("R9 irq_rx", irq_rx, 1);
        chk("R9 irq_tx", irq_tx, 1);
        chk("R9 irq_rt", irq_rt, 1);
        rd(2'd1, 'h070, "R6 level bits");
        wr(2'd3, 16'h0070);
        chk("R7 clr pulses high", {rx_clr, tx_clr, rt_clr}, 3'b111);
        @(negedge clk);
        chk("R7 clr pulses one cycle", {rx_clr, tx_clr, rt_clr}, 3'b000);
        wr(2'd3, 16'h0020);
        chk("R7 only tx_clr", {rx_clr, tx_clr, rt_clr}, 3'b010);
        rd(2'd1, 'h070, "R6 levels unaffected by clear");
        @(negedge clk); tx_lvl = 1'b0; rt_lvl = 1'b0;
        rd(2'd1, 'h010, "R6 levels follow fall");

        // R8 masked status, R9 grouping, R10 combined
        @(negedge clk); pe_pulse = 1'b1;
        @(negedge clk); pe_pulse = 1'b0;
        wr(2'd0, 16'h0011);
        rd(2'd2, 'h010, "R8 masked status");
        rd(2'd1, 'h110, "R8 raw status");
        chk("R9 irq_err masked off", irq_err, 0);
        chk("R9 irq_rx enabled", irq_rx, 1);
        chk("R10 irq_any", irq_any, 1);
        wr(2'd0, 16'h0100);
        chk("R9 irq_err enabled", irq_err, 1);
        chk("R9 irq_rx masked off", irq_rx, 0);
        rd(2'd2, 'h100, "R8 masked status err");
        wr(2'd0, 16'h0000);
        chk("R10 irq_any mask zero", irq_any, 0);

        idle(3);
        chk("R11 all responses seen", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule